// File: doc/BRIEF.md
# PHY Indirect Register Access Master

This block reads and writes 16-bit registers that sit inside a PHY and are reachable only through a narrow handshake port. A requester issues one operation at a time on a valid/ready interface. Each operation carries a direction flag, a 16-bit register address and, for writes, 16-bit data. The master turns the operation into a series of four-phase handshakes on a 20-bit control word. In each handshake it raises a strobe, waits for the PHY acknowledge to go high, lowers the strobe and waits for the acknowledge to go low. The master then reports completion with a one-cycle done pulse, an error flag and, for reads, the returned data.

The acknowledge is sampled once every `POLL_GAP` clock cycles, with at most `POLL_TRIES` samples per wait. A wait that never sees the expected level aborts the operation. The abort clears every strobe and returns the block to idle.

States and transitions:
- `ST_IDLE` goes to `ST_ADR_SET` on an accepted request.
- `ST_ADR_SET` goes to `ST_ADR_CLR` when ack is seen high.
- `ST_ADR_CLR` goes to `ST_DAT_SET` (write) or `ST_RD_SET` (read) when ack is seen low.
- A write then runs `ST_DAT_SET`, `ST_DAT_CLR`, `ST_WR_SET`, `ST_WR_CLR` and ends in `ST_DONE`.
- A read then runs `ST_RD_SET`, `ST_RD_CLR` and ends in `ST_DONE`.
- Any wait state goes to `ST_FAIL` on a timeout.
- `ST_DONE` and `ST_FAIL` both return to `ST_IDLE`.

Top module: `phy_regacc_master`

## Requirements
- R1: After reset, req_ready is 1, phy_ctrl is all zero, and rsp_done and rsp_error are 0.
- R2: The control word layout is fixed: bits 15:0 carry the address or data field, bit 16 is capture-address, bit 17 is capture-data, bit 18 is the write strobe and bit 19 is the read strobe. At most one of bits 19:16 is high in any cycle.
- R3: In the cycle after a request is accepted, phy_ctrl holds the address in bits 15:0 with only bit 16 set. Once ack is seen high, bit 16 drops while the address stays on the field, and the master waits for ack low.
- R4: A write then captures the data (data on the field with bit 17, ack high, bit 17 dropped, ack low). It then pulses the write strobe (bit 18 alone, ack high, strobe dropped, ack low) and ends with phy_ctrl all zero. The addressed PHY register takes the data.
- R5: A read then raises bit 19 alone. When ack is seen high it captures phy_stat[15:0], drives phy_ctrl to zero and waits for ack low. The captured value appears on rsp_rdata with rsp_done and stays there until the next read.
- R6: The ack (phy_stat bit 16) is sampled in the first cycle of each wait and then every POLL_GAP cycles, at most POLL_TRIES times. An ack that first shows in the cycle of the last sample still completes the step.
- R7: If the expected ack level is not seen by the last sample, the cycle after it shows rsp_done and rsp_error together with phy_ctrl zero. The block then returns to idle. With no ack at all, this happens (POLL_TRIES-1)*POLL_GAP+1 clock edges after acceptance.
- R8: req_ready is high only in idle. A request presented while an operation is running is ignored and changes no PHY register.
- R9: rsp_done is a single-cycle pulse, and rsp_error is never high without rsp_done.
- R10: An ack that stays high after a strobe drops makes the falling-edge wait time out, with rsp_error set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | Timeout abort, valid with rsp_done |
| rsp_rdata | output | 16 | Last read data |
| phy_ctrl | output | 20 | Control word to the PHY |
| phy_stat | input | 17 | Bit 16 ack, bits 15:0 read data |

## Verification
The address word with capture-address appears one clock edge after the accepting edge. The bench samples it on the falling edge that follows. A silent PHY gives done and error exactly (POLL_TRIES-1)*POLL_GAP+1 edges after acceptance. The bench counts rising edges from acceptance and compares that count against the formula. Ack latencies of 71 and 72 cycles straddle the last sample at offset 72, so the first latency must pass and the second must fail. Every output is read on falling edges, and done is checked again one falling edge later to confirm it lasts one cycle.

// File: rtl/phy_regacc_pkg.sv
package phy_regacc_pkg;

    localparam int FIELD_W    = 16;
    localparam int CTRL_W     = 20;
    localparam int STAT_W     = 17;
    localparam int CAP_ADR_POS = 16;
    localparam int CAP_DAT_POS = 17;
    localparam int WR_POS      = 18;
    localparam int RD_POS      = 19;
    localparam int ACK_POS     = 16;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADR_SET,
        ST_ADR_CLR,
        ST_DAT_SET,
        ST_DAT_CLR,
        ST_WR_SET,
        ST_WR_CLR,
        ST_RD_SET,
        ST_RD_CLR,
        ST_DONE,
        ST_FAIL
    } seq_state_t;

    typedef struct packed {
        logic               rd;
        logic               wr;
        logic               cap_dat;
        logic               cap_adr;
        logic [FIELD_W-1:0] field;
    } ctrl_fields_t;

endpackage

// File: rtl/phy_regacc_poll.sv
module phy_regacc_poll #(
    parameter int TRIES = 10,
    parameter int GAP   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic expect_hi,
    input  logic ack,
    output logic hit,
    output logic timeout
);
    localparam int GW = (GAP > 1) ? $clog2(GAP) : 1;
    localparam int TW = (TRIES > 1) ? $clog2(TRIES) : 1;
    localparam logic [GW-1:0] GAP_RELOAD = GW'(GAP - 1);
    localparam logic [TW-1:0] LAST_TRY   = TW'(TRIES - 1);

    logic [GW-1:0] gap_q;
    logic [TW-1:0] tries_q;
    logic          sample;
    logic          match;

    assign sample  = (gap_q == '0);
    assign match   = (ack == expect_hi);
    assign hit     = sample && match;
    assign timeout = sample && !match && (tries_q == LAST_TRY);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            gap_q   <= '0;
            tries_q <= '0;
        end else if (sample) begin
            gap_q   <= GAP_RELOAD;
            tries_q <= tries_q + 1'b1;
        end else begin
            gap_q   <= gap_q - 1'b1;
        end
    end
endmodule

// File: rtl/phy_regacc_pack.sv
module phy_regacc_pack
    import phy_regacc_pkg::*;
(
    input  ctrl_fields_t      fields,
    output logic [CTRL_W-1:0] ctrl_word
);
    always_comb begin
        ctrl_word                 = '0;
        ctrl_word[FIELD_W-1:0]    = fields.field;
        ctrl_word[CAP_ADR_POS]    = fields.cap_adr;
        ctrl_word[CAP_DAT_POS]    = fields.cap_dat;
        ctrl_word[WR_POS]         = fields.wr;
        ctrl_word[RD_POS]         = fields.rd;
    end
endmodule

// File: rtl/phy_regacc_fsm.sv
module phy_regacc_fsm
    import phy_regacc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [FIELD_W-1:0] req_addr,
    input  logic [FIELD_W-1:0] req_wdata,
    input  logic [FIELD_W-1:0] rd_word,
    input  logic               hit,
    input  logic               timeout,
    output logic               req_ready,
    output logic               rsp_done,
    output logic               rsp_error,
    output logic [FIELD_W-1:0] rsp_rdata,
    output ctrl_fields_t       fields,
    output logic               poll_clear,
    output logic               poll_expect_hi
);
    seq_state_t         state_q, state_d;
    logic [FIELD_W-1:0] addr_q, wdata_q, rdata_q;
    logic               is_wr_q;
    logic               in_wait;
    logic               accept;

    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign rsp_rdata = rdata_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request and response holding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            is_wr_q <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                is_wr_q <= req_write;
            end
            if (state_q == ST_RD_SET && hit) rdata_q <= rd_word;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_ADR_SET;
            ST_ADR_SET: if (hit) state_d = ST_ADR_CLR;
                        else if (timeout) state_d = ST_FAIL;
            ST_ADR_CLR: if (hit) state_d = is_wr_q ? ST_DAT_SET : ST_RD_SET;
                        else if (timeout) state_d = ST_FAIL;
            ST_DAT_SET: if (hit) state_d = ST_DAT_CLR;
                        else if (timeout) state_d = ST_FAIL;
            ST_DAT_CLR: if (hit) state_d = ST_WR_SET;
                        else if (timeout) state_d = ST_FAIL;
            ST_WR_SET:  if (hit) state_d = ST_WR_CLR;
                        else if (timeout) state_d = ST_FAIL;
            ST_WR_CLR:  if (hit) state_d = ST_DONE;
                        else if (timeout) state_d = ST_FAIL;
            ST_RD_SET:  if (hit) state_d = ST_RD_CLR;
                        else if (timeout) state_d = ST_FAIL;
            ST_RD_CLR:  if (hit) state_d = ST_DONE;
                        else if (timeout) state_d = ST_FAIL;
            ST_DONE:    state_d = ST_IDLE;
            ST_FAIL:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        fields         = '0;
        req_ready      = 1'b0;
        rsp_done       = 1'b0;
        rsp_error      = 1'b0;
        in_wait        = 1'b1;
        poll_expect_hi = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                in_wait   = 1'b0;
            end
            ST_ADR_SET: begin
                fields.field   = addr_q;
                fields.cap_adr = 1'b1;
                poll_expect_hi = 1'b1;
            end
            ST_ADR_CLR: fields.field = addr_q;
            ST_DAT_SET: begin
                fields.field   = wdata_q;
                fields.cap_dat = 1'b1;
                poll_expect_hi = 1'b1;
            end
            ST_DAT_CLR: fields.field = wdata_q;
            ST_WR_SET: begin
                fields.wr      = 1'b1;
                poll_expect_hi = 1'b1;
            end
            ST_WR_CLR: fields.field = wdata_q;
            ST_RD_SET: begin
                fields.rd      = 1'b1;
                poll_expect_hi = 1'b1;
            end
            ST_RD_CLR: ;
            ST_DONE: begin
                rsp_done = 1'b1;
                in_wait  = 1'b0;
            end
            ST_FAIL: begin
                rsp_done  = 1'b1;
                rsp_error = 1'b1;
                in_wait   = 1'b0;
            end
            default: in_wait = 1'b0;
        endcase
        poll_clear = !in_wait || hit || timeout;
    end
endmodule

// File: rtl/phy_regacc_master.sv
module phy_regacc_master
    import phy_regacc_pkg::*;
#(
    parameter int POLL_TRIES = 10,
    parameter int POLL_GAP   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [FIELD_W-1:0] req_addr,
    input  logic [FIELD_W-1:0] req_wdata,
    output logic               rsp_done,
    output logic               rsp_error,
    output logic [FIELD_W-1:0] rsp_rdata,
    output logic [CTRL_W-1:0]  phy_ctrl,
    input  logic [STAT_W-1:0]  phy_stat
);
    ctrl_fields_t fields;
    logic         hit, timeout, poll_clear, poll_expect_hi;

    phy_regacc_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_write      (req_write),
        .req_addr       (req_addr),
        .req_wdata      (req_wdata),
        .rd_word        (phy_stat[FIELD_W-1:0]),
        .hit            (hit),
        .timeout        (timeout),
        .req_ready      (req_ready),
        .rsp_done       (rsp_done),
        .rsp_error      (rsp_error),
        .rsp_rdata      (rsp_rdata),
        .fields         (fields),
        .poll_clear     (poll_clear),
        .poll_expect_hi (poll_expect_hi)
    );

    phy_regacc_poll #(
        .TRIES (POLL_TRIES),
        .GAP   (POLL_GAP)
    ) u_poll (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (poll_clear),
        .expect_hi (poll_expect_hi),
        .ack       (phy_stat[ACK_POS]),
        .hit       (hit),
        .timeout   (timeout)
    );

    phy_regacc_pack u_pack (
        .fields    (fields),
        .ctrl_word (phy_ctrl)
    );
endmodule

// File: rtl/phy_regacc_chk.sv
module phy_regacc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [15:0] req_addr,
    input logic        rsp_done,
    input logic        rsp_error,
    input logic [19:0] phy_ctrl
);
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phy_ctrl[19:16]) <= 1); // R2

    AST_ADDR_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (phy_ctrl[19:16] == 4'b0001) && (phy_ctrl[15:0] == $past(req_addr))); // R3

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (phy_ctrl == '0) && !rsp_done); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R9

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_error |-> rsp_done); // R9

    AST_DONE_CTRL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (phy_ctrl == '0)); // R7
endmodule

bind phy_regacc_master phy_regacc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .rsp_done  (rsp_done),
    .rsp_error (rsp_error),
    .phy_ctrl  (phy_ctrl)
);

// File: tb/phy_regacc_master_tb.sv
`timescale 1ns/1ps
module phy_regacc_master_tb;
    localparam int TRIES = 10;
    localparam int GAP   = 8;
    localparam int SILENT_EDGES = (TRIES - 1) * GAP + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_done, rsp_error;
    logic [15:0] rsp_rdata;
    logic [19:0] phy_ctrl;
    logic [16:0] phy_stat;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    phy_regacc_master #(.POLL_TRIES(TRIES), .POLL_GAP(GAP)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
        .phy_ctrl(phy_ctrl), .phy_stat(phy_stat)
    );

    // ---------------- PHY model ----------------
    int          m_lat = 0;
    bit          m_noack = 0;
    bit          m_stuck = 0;
    logic        m_ack;
    int          m_cnt;
    logic [19:0] m_prev;
    logic [15:0] m_addr, m_data;
    bit          m_addr_ok, m_dat_ok;
    int          m_order_err = 0;
    int          m_multi_err = 0;
    logic [15:0] m_regs [16];

    assign phy_stat = {m_ack, (phy_ctrl[19] ? m_regs[m_addr[3:0]] : 16'h0000)};

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ack <= 1'b0; m_cnt <= 0; m_prev <= '0;
            m_addr_ok <= 0; m_dat_ok <= 0; m_addr <= '0; m_data <= '0;
            for (int i = 0; i < 16; i++) m_regs[i] <= '0;
        end else begin
            if (m_noack) begin
                m_ack <= 1'b0; m_cnt <= 0;
            end else if (m_stuck && m_ack) begin
                m_ack <= 1'b1;
            end else if ((|phy_ctrl[19:16]) != m_ack) begin
                if (m_cnt >= m_lat) begin
                    m_ack <= |phy_ctrl[19:16]; m_cnt <= 0;
                end else m_cnt <= m_cnt + 1;
            end else m_cnt <= 0;
            if ($countones(phy_ctrl[19:16]) > 1) m_multi_err <= m_multi_err + 1;
            m_prev <= phy_ctrl;
            if (phy_ctrl[16] && !m_prev[16]) begin
                m_addr <= phy_ctrl[15:0]; m_addr_ok <= 1; m_dat_ok <= 0;
            end
            if (phy_ctrl[17] && !m_prev[17]) begin
                if (!m_addr_ok) m_order_err <= m_order_err + 1;
                m_data <= phy_ctrl[15:0]; m_dat_ok <= 1;
            end
            if (phy_ctrl[18] && !m_prev[18]) begin
                if (!m_dat_ok) m_order_err <= m_order_err + 1;
                else m_regs[m_addr[3:0]] <= m_data;
                m_addr_ok <= 0; m_dat_ok <= 0;
            end
            if (phy_ctrl[19] && !m_prev[19]) begin
                if (!m_addr_ok) m_order_err <= m_order_err + 1;
                m_addr_ok <= 0;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    logic [19:0] first_ctrl;
    bit          done_after;

    task automatic run(input bit wr, input logic [15:0] a, input logic [15:0] d,
                       output logic [15:0] rd, output bit err, output int n);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        first_ctrl = phy_ctrl;
        n = 0;
        while (!rsp_done) begin
            @(posedge clk); n++;
            @(negedge clk);
        end
        rd  = rsp_rdata;
        err = rsp_error;
        @(negedge clk);
        done_after = rsp_done;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check("R1 ready", req_ready, 1);
        check("R1 ctrl", phy_ctrl, 0);
        check("R1 done/error", {rsp_done, rsp_error}, 0);
    endtask

    task automatic t_write_read(input logic [15:0] a, input logic [15:0] d);
        logic [15:0] rd; bit err; int n;
        run(1, a, d, rd, err, n);
        check("R3 address word after accept", first_ctrl, {4'b0001, a});
        check("R4 write no error", err, 0);
        check("R9 done single cycle", done_after, 0);
        check("R4 ctrl zero after write", phy_ctrl, 0);
        run(0, a, 16'h0, rd, err, n);
        check("R5 read no error", err, 0);
        check("R5 read data", rd, d);
    endtask

    task automatic t_order();
        check("R2 one strobe at a time", m_multi_err, 0);
        check("R4 strobe ordering", m_order_err, 0);
    endtask

    task automatic t_latency_edge();
        logic [15:0] rd; bit err; int n;
        m_lat = SILENT_EDGES - 2;   // ack first seen on the last sample
        run(1, 16'h0009, 16'h5A5A, rd, err, n);
        check("R6 ack on last sample completes", err, 0);
        run(0, 16'h0009, 16'h0, rd, err, n);
        check("R6 slow read data", rd, 16'h5A5A);
        m_lat = SILENT_EDGES - 1;   // one cycle too late
        run(1, 16'h000A, 16'h1111, rd, err, n);
        check("R6 ack after last sample fails", err, 1);
        m_lat = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_silent();
        logic [15:0] rd; bit err; int n;
        m_noack = 1;
        run(0, 16'h0002, 16'h0, rd, err, n);
        check("R7 timeout error", err, 1);
        check("R7 timeout edge count", n, SILENT_EDGES);
        check("R7 ctrl zero after abort", phy_ctrl, 0);
        check("R7 back to idle", req_ready, 1);
        m_noack = 0;
    endtask

    task automatic t_stuck();
        logic [15:0] rd; bit err; int n;
        m_stuck = 1;
        run(1, 16'h0004, 16'h7777, rd, err, n);
        check("R10 stuck ack error", err, 1);
        check("R10 register untouched", m_regs[4], 16'h0000);
        m_stuck = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_busy();
        logic [15:0] rd; bit err; int n; int hi;
        run(1, 16'h0005, 16'h1234, rd, err, n);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 16'h0003; req_wdata = 16'hC0DE;
        @(posedge clk);
        @(negedge clk);
        req_addr = 16'h0005; req_wdata = 16'hDEAD;
        hi = 0;
        for (int i = 0; i < 20; i++) begin
            if (req_ready) hi++;
            @(negedge clk);
        end
        req_valid = 0;
        check("R8 ready low while busy", hi, 0);
        while (!rsp_done) @(negedge clk);
        @(negedge clk);
        run(0, 16'h0005, 16'h0, rd, err, n);
        check("R8 busy request ignored", rd, 16'h1234);
        run(0, 16'h0003, 16'h0, rd, err, n);
        check("R8 first request completed", rd, 16'hC0DE);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_write_read(16'h1001, 16'hA5C3);
        t_write_read(16'h0007, 16'hFFFF);
        t_write_read(16'h100D, 16'h0001);
        t_busy();
        t_latency_edge();
        t_silent();
        t_stuck();
        t_order();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule